// File: doc/BRIEF.md
# Parity-Tracked Fault-Avoiding Victim Selector

This block sits beside the tag and data arrays of a small set-associative cache and keeps a health record for every line. Each time a line is read, the caller presents the data word and the parity bit stored with it. The block checks even parity and shifts the pass/fail outcome into that line's two-entry history. When two checks in a row on the same line fail, the line is flagged as vulnerable. The flag stays set until reset.

When the cache needs to refill a set, the caller raises a fill request with the set index. One clock later the block answers with a victim way. The answer never names a vulnerable line. Among the lines still in service, an empty line is preferred, and a per-set rotating pointer spreads allocations across the ways. A line that has failed only once stays in service. If every way of the set is flagged, the block reports that no victim exists and allocates nothing. A parity check and a fill that touch the same set in the same cycle are ordered so that the fill already sees the updated flag.

Top module: `fault_aware_victim_sel`

## Requirements
- R1: A check fails when the XOR over the data word and its stored parity bit is 1 (even parity). `par_err` is high in the cycle after `chk_valid` exactly when that check failed.
- R2: Each line keeps a 2-bit history that shifts in 1 for a failed check and 0 for a passing one. The line becomes vulnerable when both history bits are 1 after a shift, meaning two consecutive checks on that line failed.
- R3: A single failure, or two failures separated by a passing check, leaves the line eligible as a victim.
- R4: The vulnerable flag is sticky. Later passing checks do not clear it, and only reset does.
- R5: `vic_way` never names a way that is vulnerable in the requested set.
- R6: The victim is the first invalid, non-vulnerable way found by a circular search starting at the set's pointer. If there is none, it is the first non-vulnerable way from that pointer. On allocation, the way is marked valid and the set's pointer moves to the way after the victim, wrapping from the last way to way 0.
- R7: If every way of the set is vulnerable, `no_victim` is 1 and `vic_valid` is 0 in the result cycle, and nothing is allocated.
- R8: The result of a fill request is registered and appears in the cycle after the request. `vic_valid` and `no_victim` are 0 in every cycle that does not follow a request.
- R9: When a check on a line and a fill to that line's set happen in the same cycle, the fill sees the flag after that check's history update.
- R10: A synchronous active-high reset clears all histories, flags, valid bits, pointers and outputs in one cycle. After reset, the first fill to any set returns way 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | A line is being read; check its parity |
| chk_set | input | SET_W | Set index of the line being checked |
| chk_way | input | WAY_W | Way index of the line being checked |
| chk_data | input | DATA_W | Data word read from the line |
| chk_par | input | 1 | Parity bit stored with the word |
| fill_req | input | 1 | Request a victim for a refill |
| fill_set | input | SET_W | Set index of the refill |
| par_err | output | 1 | Registered parity failure of the previous cycle's check |
| vic_valid | output | 1 | Registered: a victim was chosen and allocated |
| vic_way | output | WAY_W | Registered victim way |
| no_victim | output | 1 | Registered: every way of the set is vulnerable |

## Verification
The bench builds the block with 4 ways, 8 sets and 16-bit data words. With 4 ways, a few fills are enough to reach pointer wrap-around, to skip a flagged way during rotation, and to exhaust a whole set for the no-victim case. With 8 sets, one set can be given to each scenario so that scenarios do not interfere. The narrow data word keeps the parity stimulus readable, while the check still covers the full XOR reduction.

// File: rtl/fav_pkg.sv
package fav_pkg;

    // Default geometry of the cache whose lines are tracked.
    localparam int DEF_WAYS   = 4;
    localparam int DEF_SETS   = 16;
    localparam int DEF_DATA_W = 32;

    // Two-entry outcome history of one line: bit 0 is the newest result.
    typedef logic [1:0] hist_t;

    // Shift a new outcome (1 = failed) into the history.
    function automatic hist_t hist_shift(hist_t h, logic failed);
        return {h[0], failed};
    endfunction

    // A history full of failures flags the line.
    function automatic logic hist_alarm(hist_t h);
        return &h;
    endfunction

    // Circular successor of a way index.
    function automatic int way_after(int w, int ways);
        return (w == ways - 1) ? 0 : w + 1;
    endfunction

endpackage

// File: rtl/fav_parity_chk.sv
module fav_parity_chk #(
    parameter int DATA_W = fav_pkg::DEF_DATA_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    output logic              fail
);
    // Even parity: the word and its stored bit together carry an even count of ones.
    always_comb begin
        fail = ^{data, par};
    end
endmodule

// File: rtl/fav_line_health.sv
module fav_line_health (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic fail,
    output logic vuln_q,
    output logic vuln_next
);
    import fav_pkg::*;

    hist_t hist_q;
    hist_t hist_new;

    always_comb begin
        hist_new  = hist_shift(hist_q, fail);
        vuln_next = vuln_q | (upd & hist_alarm(hist_new));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            vuln_q <= 1'b0;
        end else begin
            if (upd) begin
                hist_q <= hist_new;
            end
            vuln_q <= vuln_next;
        end
    end
endmodule

// File: rtl/fav_victim_pick.sv
module fav_victim_pick #(
    parameter int NUM_WAYS = fav_pkg::DEF_WAYS,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0] elig,
    input  logic [NUM_WAYS-1:0] free,
    input  logic [WAY_W-1:0]    start,
    output logic                found,
    output logic [WAY_W-1:0]    way
);
    logic             hit_free;
    logic             hit_any;
    logic [WAY_W-1:0] way_free;
    logic [WAY_W-1:0] way_any;
    int               idx;

    always_comb begin
        hit_free = 1'b0;
        hit_any  = 1'b0;
        way_free = '0;
        way_any  = '0;
        idx      = 0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            idx = (int'(start) + i) % NUM_WAYS;
            if (!hit_free && free[idx]) begin
                hit_free = 1'b1;
                way_free = WAY_W'(idx);
            end
            if (!hit_any && elig[idx]) begin
                hit_any = 1'b1;
                way_any = WAY_W'(idx);
            end
        end
        found = hit_free | hit_any;
        way   = hit_free ? way_free : way_any;
    end
endmodule

// File: rtl/fault_aware_victim_sel.sv
module fault_aware_victim_sel #(
    parameter int NUM_WAYS = fav_pkg::DEF_WAYS,
    parameter int NUM_SETS = fav_pkg::DEF_SETS,
    parameter int DATA_W   = fav_pkg::DEF_DATA_W,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_valid,
    input  logic [SET_W-1:0]  chk_set,
    input  logic [WAY_W-1:0]  chk_way,
    input  logic [DATA_W-1:0] chk_data,
    input  logic              chk_par,
    input  logic              fill_req,
    input  logic [SET_W-1:0]  fill_set,
    output logic              par_err,
    output logic              vic_valid,
    output logic [WAY_W-1:0]  vic_way,
    output logic              no_victim
);
    import fav_pkg::*;

    localparam int LINES = NUM_SETS * NUM_WAYS;

    logic                chk_fail;
    logic [LINES-1:0]    vuln_flat;
    logic [LINES-1:0]    vuln_next_flat;
    logic [LINES-1:0]    valid_q;
    logic [WAY_W-1:0]    ptr_q [NUM_SETS];
    logic [NUM_WAYS-1:0] row_elig;
    logic [NUM_WAYS-1:0] row_free;
    logic                pick_found;
    logic [WAY_W-1:0]    pick_way;
    int                  row_base;

    fav_parity_chk #(.DATA_W(DATA_W)) parity_i (
        .data (chk_data),
        .par  (chk_par),
        .fail (chk_fail)
    );

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            logic upd;
            assign upd = chk_valid && (chk_set == SET_W'(s)) && (chk_way == WAY_W'(w));
            fav_line_health health_i (
                .clk       (clk),
                .rst       (rst),
                .upd       (upd),
                .fail      (chk_fail),
                .vuln_q    (vuln_flat[s*NUM_WAYS + w]),
                .vuln_next (vuln_next_flat[s*NUM_WAYS + w])
            );
        end
    end

    // Eligibility of the requested set, taken after this cycle's history update.
    always_comb begin
        row_base = int'(fill_set) * NUM_WAYS;
        for (int w = 0; w < NUM_WAYS; w++) begin
            row_elig[w] = !vuln_next_flat[row_base + w];
            row_free[w] = row_elig[w] && !valid_q[row_base + w];
        end
    end

    fav_victim_pick #(.NUM_WAYS(NUM_WAYS)) pick_i (
        .elig  (row_elig),
        .free  (row_free),
        .start (ptr_q[fill_set]),
        .found (pick_found),
        .way   (pick_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= '0;
            par_err   <= 1'b0;
            vic_valid <= 1'b0;
            vic_way   <= '0;
            no_victim <= 1'b0;
            for (int s = 0; s < NUM_SETS; s++) begin
                ptr_q[s] <= '0;
            end
        end else begin
            par_err   <= chk_valid && chk_fail;
            vic_valid <= fill_req && pick_found;
            no_victim <= fill_req && !pick_found;
            if (fill_req && pick_found) begin
                vic_way                        <= pick_way;
                valid_q[row_base + int'(pick_way)] <= 1'b1;
                ptr_q[fill_set]                <= WAY_W'(way_after(int'(pick_way), NUM_WAYS));
            end
        end
    end
endmodule

// File: rtl/fav_checker.sv
module fav_checker #(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 16,
    parameter int DATA_W   = 32,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int LINES = NUM_SETS * NUM_WAYS
) (
    input logic              clk,
    input logic              rst,
    input logic              chk_valid,
    input logic [DATA_W-1:0] chk_data,
    input logic              chk_par,
    input logic              fill_req,
    input logic [SET_W-1:0]  fill_set,
    input logic              par_err,
    input logic              vic_valid,
    input logic [WAY_W-1:0]  vic_way,
    input logic              no_victim,
    input logic [LINES-1:0]  vuln_flat
);
    // R1
    par_err_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && (^{chk_data, chk_par})) |=> par_err);

    // R1
    par_err_needs_chk: assert property (@(posedge clk) disable iff (rst)
        par_err |-> $past(chk_valid));

    // R4
    vuln_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (|($past(vuln_flat) & ~vuln_flat)) == 1'b0);

    // R5
    no_vuln_victim_chk: assert property (@(posedge clk) disable iff (rst)
        vic_valid |-> !vuln_flat[int'($past(fill_set)) * NUM_WAYS + int'(vic_way)]);

    // R7
    answer_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(vic_valid && no_victim));

    // R8
    fill_answered_chk: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> (vic_valid || no_victim));

    // R8
    answer_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (vic_valid || no_victim) |-> $past(fill_req));
endmodule

bind fault_aware_victim_sel fav_checker #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_SETS (NUM_SETS),
    .DATA_W   (DATA_W)
) checker_i (
    .clk       (clk),
    .rst       (rst),
    .chk_valid (chk_valid),
    .chk_data  (chk_data),
    .chk_par   (chk_par),
    .fill_req  (fill_req),
    .fill_set  (fill_set),
    .par_err   (par_err),
    .vic_valid (vic_valid),
    .vic_way   (vic_way),
    .no_victim (no_victim),
    .vuln_flat (vuln_flat)
);

// File: tb/fault_aware_victim_sel_tb.sv
module fault_aware_victim_sel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WAYS  = 4;
    localparam int SETS  = 8;
    localparam int DW    = 16;
    localparam logic [DW-1:0] EVEN_WORD = 16'hA5C3;  // eight ones

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chk_valid = 1'b0;
    logic [2:0]    chk_set = '0;
    logic [1:0]    chk_way = '0;
    logic [DW-1:0] chk_data = '0;
    logic          chk_par = 1'b0;
    logic          fill_req = 1'b0;
    logic [2:0]    fill_set = '0;
    logic          par_err;
    logic          vic_valid;
    logic [1:0]    vic_way;
    logic          no_victim;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_aware_victim_sel #(.NUM_WAYS(WAYS), .NUM_SETS(SETS), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_set(chk_set),
        .chk_way(chk_way), .chk_data(chk_data), .chk_par(chk_par),
        .fill_req(fill_req), .fill_set(fill_set), .par_err(par_err),
        .vic_valid(vic_valid), .vic_way(vic_way), .no_victim(no_victim)
    );

    task automatic expect_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; chk_valid = 1'b0; fill_req = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R10: outputs cleared
        expect_eq("R10 par_err", par_err, 0);
        expect_eq("R10 vic_valid", vic_valid, 0);
        expect_eq("R10 no_victim", no_victim, 0);
    endtask

    // One parity check; bad selects an odd-parity word. R1 verified on par_err.
    task automatic do_check(input int s, input int w, input bit bad);
        @(negedge clk);
        chk_valid = 1'b1; chk_set = 3'(s); chk_way = 2'(w);
        chk_data = EVEN_WORD; chk_par = bad;
        @(negedge clk);
        chk_valid = 1'b0;
        expect_eq("R1 par_err", par_err, int'(bad));
    endtask

    task automatic fill_expect(input int s, input int exp_way, input bit exp_none,
                               input string req);
        @(negedge clk);
        fill_req = 1'b1; fill_set = 3'(s);
        @(negedge clk);
        fill_req = 1'b0;
        expect_eq({req, " vic_valid"}, vic_valid, exp_none ? 0 : 1);
        expect_eq({req, " no_victim"}, no_victim, exp_none ? 1 : 0);
        if (!exp_none) expect_eq({req, " vic_way"}, vic_way, exp_way);
    endtask

    task automatic t_reset_fill();
        do_reset();
        fill_expect(0, 0, 0, "R10 first fill");
    endtask

    task automatic t_parity();
        do_check(7, 3, 0);
        do_check(7, 3, 1);
        do_check(7, 3, 0);
    endtask

    task automatic t_rotation();
        fill_expect(0, 1, 0, "R6 order");
        fill_expect(0, 2, 0, "R6 order");
        fill_expect(0, 3, 0, "R6 order");
        fill_expect(0, 0, 0, "R6 wrap");
        fill_expect(0, 1, 0, "R6 reuse");
        @(negedge clk);
        // R8: no answer without a request
        expect_eq("R8 idle vic_valid", vic_valid, 0);
        expect_eq("R8 idle no_victim", no_victim, 0);
    endtask

    task automatic t_vulnerable();
        do_check(1, 2, 1);
        do_check(1, 2, 1);
        fill_expect(1, 0, 0, "R5 skip");
        fill_expect(1, 1, 0, "R5 skip");
        fill_expect(1, 3, 0, "R2 flagged way skipped");
        fill_expect(1, 0, 0, "R5 wrap");
        fill_expect(1, 1, 0, "R5 wrap");
    endtask

    task automatic t_sticky();
        do_check(1, 2, 0);
        do_check(1, 2, 0);
        fill_expect(1, 3, 0, "R4 still skipped");
    endtask

    task automatic t_single_fail();
        do_check(2, 1, 1);
        do_check(2, 1, 0);
        do_check(2, 1, 1);
        fill_expect(2, 0, 0, "R3");
        fill_expect(2, 1, 0, "R3 once-failed way used");
        fill_expect(2, 2, 0, "R3");
        fill_expect(2, 3, 0, "R3");
    endtask

    task automatic t_all_vulnerable();
        for (int w = 0; w < WAYS; w++) begin
            do_check(3, w, 1);
            do_check(3, w, 1);
        end
        fill_expect(3, 0, 1, "R7 none");
        fill_expect(3, 0, 1, "R7 none again");
        fill_expect(6, 0, 0, "R7 other set unaffected");
    endtask

    task automatic t_same_cycle();
        do_check(4, 0, 1);
        @(negedge clk);
        chk_valid = 1'b1; chk_set = 3'd4; chk_way = 2'd0;
        chk_data = EVEN_WORD; chk_par = 1'b1;
        fill_req = 1'b1; fill_set = 3'd4;
        @(negedge clk);
        chk_valid = 1'b0; fill_req = 1'b0;
        expect_eq("R9 vic_valid", vic_valid, 1);
        expect_eq("R9 vic_way", vic_way, 1);
        expect_eq("R9 par_err", par_err, 1);
    endtask

    task automatic t_reset_clears();
        do_reset();
        fill_expect(1, 0, 0, "R10 flags cleared");
        fill_expect(3, 0, 0, "R10 flags cleared");
    endtask

    initial begin
        t_reset_fill();
        t_parity();
        t_rotation();
        t_vulnerable();
        t_sticky();
        t_single_fail();
        t_all_vulnerable();
        t_same_cycle();
        t_reset_clears();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule